// File: doc/BRIEF.md
# Frequency Lock Detector and Loop Mode Controller

This block judges whether a recovered clock is running close enough to a local reference to hand the loop over to data tracking. The reference runs at one sixty-fourth of the line rate, and the recovered clock reaches the block divided by the same ratio. Both arrive as single-cycle tick pulses in the system clock domain. Over a window of a fixed number of reference ticks, the block counts divided recovered-clock ticks. When the window closes, it compares how far that count lies from the window length against a selectable tolerance, either narrow (about 500 ppm) or wide (about 2000 ppm).

The result drives a two-state controller. The acquisition state routes the phase-frequency detector into the loop. The tracking state routes the bang-bang detector into the loop. The lock flag is high only after a window whose count stayed inside the tolerance. While the loop is still settling, windows keep passing and failing, so the flag alternates with the detector choice. A two-bit select input chooses either automatic switching or a fixed detector, and also picks the tolerance. In the fixed modes the lock flag still reports every comparison.

Top module: `freq_lock_ctrl`

## Requirements
- R1: A window spans exactly WINDOW reference ticks. It closes on the cycle that carries the last of them, and both the reference counter and the recovered-tick counter restart from zero on the following cycle.
- R2: At window close, the window is out of tolerance when the absolute difference between the recovered tick count and WINDOW exceeds the tolerance. The tolerance is TOL_NARROW when mode_sel[0] is 0 and TOL_WIDE when mode_sel[0] is 1.
- R3: The lock decision changes only at window close, and the new value appears on the cycle after the closing reference tick. Between closes, lock and use_bb stay steady while mode_sel is steady.
- R4: mode_sel decodes as follows. 2'b00 is automatic with the narrow tolerance. 2'b01 is automatic with the wide tolerance. 2'b10 forces the phase-frequency detector (use_bb = 0) with the narrow tolerance. 2'b11 forces the bang-bang detector (use_bb = 1) with the wide tolerance.
- R5: In the automatic modes, use_bb is 1 (bang-bang detector, tracking) after an in-tolerance window and 0 (phase-frequency detector, acquisition) after an out-of-tolerance window.
- R6: In every mode, lock is 1 after an in-tolerance window and 0 after an out-of-tolerance window. In automatic mode, lock therefore alternates as the windows alternate between pass and fail.
- R7: While rst is high, the block is held in acquisition with lock at 0 and both counters cleared, and a new window starts after rst is released.
- R8: A recovered tick that arrives in the same cycle as the closing reference tick counts toward the closing window. The recovered tick counter saturates at its maximum rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset of the whole block |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| vco_tick | input | 1 | One-cycle pulse per divided recovered-clock period |
| mode_sel | input | 2 | Switching mode and tolerance select (see R4) |
| lock | output | 1 | High when the last window was within tolerance |
| use_bb | output | 1 | Detector select: 1 = bang-bang detector, 0 = phase-frequency detector |

## Verification
A window's verdict is due on lock and use_bb one cycle after the closing reference tick, because only the state register sits between the counters and the outputs. The bench therefore drives each window to completion on falling edges and samples at the falling edge right after the closing rising edge. The bench also samples halfway through every window and expects the previous verdict there. A change of mode_sel reaches use_bb in the same cycle. Its effect on the tolerance shows only at the next window close, so the bench sets mode_sel at the start of a window and leaves it unchanged until that window's result has been read.

// File: rtl/flc_pkg.sv
package flc_pkg;

   typedef enum logic {
      ST_ACQ   = 1'b0,
      ST_TRACK = 1'b1
   } flc_state_e;

   typedef struct packed {
      logic forced;
      logic force_bb;
      logic wide_tol;
   } flc_mode_t;

   function automatic flc_mode_t flc_decode_mode(input logic [1:0] sel);
      flc_mode_t m;
      m.forced   = sel[1];
      m.force_bb = sel[0];
      m.wide_tol = sel[0];
      return m;
   endfunction

endpackage

// File: rtl/flc_window_counter.sv
module flc_window_counter #(
   parameter int WINDOW = 8192,
   parameter int REF_W  = $clog2(WINDOW),
   parameter int VCO_W  = $clog2(2 * WINDOW + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_tick,
   input  logic             vco_tick,
   output logic             win_done,
   output logic [VCO_W-1:0] vco_total
);

   localparam logic [REF_W-1:0] REF_LAST = REF_W'(WINDOW - 1);
   localparam logic [VCO_W-1:0] VCO_MAX  = {VCO_W{1'b1}};

   logic [REF_W-1:0] ref_cnt;
   logic [VCO_W-1:0] vco_cnt;
   logic             ref_last;

   assign ref_last = (ref_cnt == REF_LAST);
   assign win_done = ref_tick && ref_last;

   // Tick arriving alongside the closing reference tick belongs to this window.
   always_comb begin
      if (vco_cnt == VCO_MAX)
         vco_total = VCO_MAX;
      else
         vco_total = vco_cnt + VCO_W'(vco_tick);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ref_cnt <= '0;
         vco_cnt <= '0;
      end else begin
         if (ref_tick)
            ref_cnt <= ref_last ? '0 : ref_cnt + 1'b1;
         if (win_done)
            vco_cnt <= '0;
         else
            vco_cnt <= vco_total;
      end
   end

   assert_window_restart_R1: assert property (@(posedge clk) disable iff (rst)
      win_done |=> (ref_cnt == '0 && vco_cnt == '0));

   assert_vco_saturate_R8: assert property (@(posedge clk) disable iff (rst)
      (vco_cnt == VCO_MAX && !win_done) |=> (vco_cnt == VCO_MAX));

endmodule

// File: rtl/flc_tol_compare.sv
module flc_tol_compare #(
   parameter int WINDOW     = 8192,
   parameter int TOL_NARROW = 4,
   parameter int TOL_WIDE   = 16,
   parameter int VCO_W      = $clog2(2 * WINDOW + 1)
) (
   input  logic [VCO_W-1:0] vco_total,
   input  logic             wide_tol,
   output logic             beyond
);

   localparam logic [VCO_W-1:0] WIN_C    = VCO_W'(WINDOW);
   localparam logic [VCO_W-1:0] TOL_N_C  = VCO_W'(TOL_NARROW);
   localparam logic [VCO_W-1:0] TOL_W_C  = VCO_W'(TOL_WIDE);

   logic [VCO_W-1:0] diff;
   logic [VCO_W-1:0] tol;

   always_comb begin
      if (vco_total >= WIN_C)
         diff = vco_total - WIN_C;
      else
         diff = WIN_C - vco_total;
   end

   generate
      if (TOL_NARROW == TOL_WIDE) begin : g_single_tol
         assign tol = TOL_N_C;
      end else begin : g_dual_tol
         assign tol = wide_tol ? TOL_W_C : TOL_N_C;
      end
   endgenerate

   assign beyond = (diff > tol);

   always_comb begin
      assert_tol_order_R2: assert (TOL_W_C >= TOL_N_C);
   end

endmodule

// File: rtl/flc_mode_fsm.sv
module flc_mode_fsm
   import flc_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      win_done,
   input  logic      beyond,
   input  flc_mode_t mode,
   output logic      lock,
   output logic      use_bb
);

   flc_state_e state;
   flc_state_e state_nxt;

   always_comb begin
      state_nxt = state;
      if (win_done)
         state_nxt = beyond ? ST_ACQ : ST_TRACK;
   end

   always_ff @(posedge clk) begin
      if (rst)
         state <= ST_ACQ;
      else
         state <= state_nxt;
   end

   assign lock   = (state == ST_TRACK);
   assign use_bb = mode.forced ? mode.force_bb : lock;

   assert_hold_between_windows_R3: assert property (@(posedge clk) disable iff (rst)
      !win_done |=> $stable(state));

   assert_fail_to_acq_R6: assert property (@(posedge clk) disable iff (rst)
      (win_done && beyond) |=> !lock);

endmodule

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl
   import flc_pkg::*;
#(
   parameter int WINDOW     = 8192,
   parameter int TOL_NARROW = 4,
   parameter int TOL_WIDE   = 16
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       ref_tick,
   input  logic       vco_tick,
   input  logic [1:0] mode_sel,
   output logic       lock,
   output logic       use_bb
);

   localparam int REF_W = $clog2(WINDOW);
   localparam int VCO_W = $clog2(2 * WINDOW + 1);

   generate
      if (WINDOW < 2) begin : g_bad_window
         $error("WINDOW must be at least 2");
      end
      if (TOL_WIDE < TOL_NARROW || TOL_NARROW < 0) begin : g_bad_tol
         $error("tolerances must satisfy 0 <= TOL_NARROW <= TOL_WIDE");
      end
      if (TOL_WIDE >= WINDOW) begin : g_wide_tol
         $error("TOL_WIDE must be below WINDOW");
      end
   endgenerate

   flc_mode_t        mode;
   logic             win_done;
   logic [VCO_W-1:0] vco_total;
   logic             beyond;

   assign mode = flc_decode_mode(mode_sel);

   flc_window_counter #(
      .WINDOW (WINDOW),
      .REF_W  (REF_W),
      .VCO_W  (VCO_W)
   ) u_count (
      .clk       (clk),
      .rst       (rst),
      .ref_tick  (ref_tick),
      .vco_tick  (vco_tick),
      .win_done  (win_done),
      .vco_total (vco_total)
   );

   flc_tol_compare #(
      .WINDOW     (WINDOW),
      .TOL_NARROW (TOL_NARROW),
      .TOL_WIDE   (TOL_WIDE),
      .VCO_W      (VCO_W)
   ) u_cmp (
      .vco_total (vco_total),
      .wide_tol  (mode.wide_tol),
      .beyond    (beyond)
   );

   flc_mode_fsm u_fsm (
      .clk      (clk),
      .rst      (rst),
      .win_done (win_done),
      .beyond   (beyond),
      .mode     (mode),
      .lock     (lock),
      .use_bb   (use_bb)
   );

   assert_forced_pfd_R4: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == 2'b10) |-> !use_bb);

   assert_forced_bb_R4: assert property (@(posedge clk) disable iff (rst)
      (mode_sel == 2'b11) |-> use_bb);

   assert_auto_follows_lock_R5: assert property (@(posedge clk) disable iff (rst)
      (mode_sel[1] == 1'b0) |-> (use_bb == lock));

   assert_reset_acq_R7: assert property (@(posedge clk)
      $past(rst) |-> !lock);

endmodule

// File: tb/freq_lock_ctrl_tb_top.sv
module freq_lock_ctrl_tb_top;

   localparam int WIN   = 64;
   localparam int TOL_N = 1;
   localparam int TOL_W = 4;
   localparam int SLOT  = 4;
   localparam int CYC   = WIN * SLOT;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ref_tick = 1'b0;
   logic       vco_tick = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic       lock;
   logic       use_bb;

   int n_checks = 0;
   int n_fail   = 0;
   int prev_in  = 0;

   always #10 clk = ~clk;

   freq_lock_ctrl #(
      .WINDOW     (WIN),
      .TOL_NARROW (TOL_N),
      .TOL_WIDE   (TOL_W)
   ) dut_i (
      .clk      (clk),
      .rst      (rst),
      .ref_tick (ref_tick),
      .vco_tick (vco_tick),
      .mode_sel (mode_sel),
      .lock     (lock),
      .use_bb   (use_bb)
   );

   task automatic chk(input int act, input int exp, input string msg);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
      end
   endtask

   function automatic int exp_bb(input int sel, input int in_r);
      if (sel == 2) return 0;
      if (sel == 3) return 1;
      return in_r;
   endfunction

   // One full window with n recovered ticks spread evenly; stops after ncyc cycles.
   task automatic run_window(input int sel, input int n, input int ncyc);
      mode_sel = 2'(sel);
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         ref_tick = ((c % SLOT) == SLOT - 1);
         vco_tick = (((c * n) / CYC) != (((c + 1) * n) / CYC));
         if (c == CYC / 2) begin
            chk(int'(lock), prev_in, $sformatf("R3 mid-window lock sel=%0d n=%0d", sel, n));
            chk(int'(use_bb), exp_bb(sel, prev_in),
                $sformatf("R4 mid-window use_bb sel=%0d n=%0d", sel, n));
         end
      end
      @(negedge clk);
      ref_tick = 1'b0;
      vco_tick = 1'b0;
   endtask

   task automatic full_window(input int sel, input int n);
      int d;
      int tol;
      int in_r;
      run_window(sel, n, CYC);
      d    = (n > WIN) ? n - WIN : WIN - n;
      tol  = sel[0] ? TOL_W : TOL_N;
      in_r = (d <= tol) ? 1 : 0;
      chk(int'(lock), in_r, $sformatf("R2 R6 lock sel=%0d n=%0d", sel, n));
      chk(int'(use_bb), exp_bb(sel, in_r), $sformatf("R4 R5 use_bb sel=%0d n=%0d", sel, n));
      prev_in = in_r;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(int'(lock), 0, "R7 reset lock");
      chk(int'(use_bb), 0, "R7 reset use_bb");
      rst = 1'b0;

      // Tolerance sweep in every mode, windows alternate pass/fail (R1, R2, R6, R8 boundary tick).
      for (int sel = 0; sel < 4; sel++) begin
         for (int dlt = -6; dlt <= 6; dlt++) begin
            full_window(sel, WIN + dlt);
         end
      end

      // Alternation in automatic mode: pass, fail, pass (R5, R6).
      full_window(0, WIN);
      full_window(0, WIN + 2);
      full_window(0, WIN - 1);

      // Extremes: no recovered ticks, and a tick every cycle driving saturation (R8).
      full_window(1, 0);
      full_window(0, WIN);
      full_window(1, CYC);
      full_window(3, CYC);

      // Reset mid-window after a passing window (R7), then a fresh window (R1).
      full_window(0, WIN);
      run_window(0, WIN + 20, CYC / 2 + 3);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(int'(lock), 0, "R7 reset mid-window lock");
      chk(int'(use_bb), 0, "R7 reset mid-window use_bb");
      rst = 1'b0;
      prev_in = 0;
      full_window(0, WIN + 1);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule